// File: doc/BRIEF.md
# Predicated Vector Element Loop Sequencer

This block turns one arithmetic operation, written with scalar register numbers, into a run of per-element operations. A one-cycle start pulse captures a vector length, a predicate mask, three base register numbers (destination and two sources) and one vector flag per operand. From the following cycle on, the block issues one element per clock. Each issue carries three register indices, the element number and a write-enable taken from the predicate. A downstream register file and execution unit carry out each element.

Each operand steps on its own. A vector operand's index advances by one per element. A scalar operand's index stays at its base. If the destination is scalar, the run stops at the first element whose predicate bit is set, so at most one result is written. If the destination is a vector and both sources are scalars, one value is copied into consecutive registers (a splat). Two offset state registers expose the loop position for context save and return to zero when the run ends.

Top module: `elem_loop_seq`

## Requirements
- R1: After a synchronous active-high reset, busy, done, issue_valid, issue_we, src_off and sec_off are all 0.
- R2: All inputs are captured on the edge where start is sampled high while busy is 0. busy is 1 from the next cycle until the cycle done rises. A start pulse while busy is 1 is ignored and leaves the running sequence unchanged.
- R3: While running, exactly one element is issued per cycle. The issued element numbers are 0, 1, 2 and so on, with no gap.
- R4: issue_we for element i equals bit i of the captured predicate mask, where bit 0 is the least significant bit. A masked-off element is still issued, with issue_we at 0.
- R5: Each issued index is its base number plus its own offset, modulo 32. The offset of a vector-flagged operand equals the number of elements issued before this one. A scalar-flagged operand's offset is always 0.
- R6: With a scalar destination, the element with the first set predicate bit is the last one issued.
- R7: No element numbered VL or higher is issued. With no earlier stop, the last element issued is VL-1.
- R8: In each issue cycle, src_off equals the element number and sec_off equals the destination offset.
- R9: done is a one-cycle pulse in the cycle after the last issue. In that cycle issue_valid, busy, src_off and sec_off are 0.
- R10: With VL = 0, nothing is issued, and done rises in the second cycle after the start edge.
- R11: With a vector destination and two scalar sources, every predicated element writes the same sum of the two source registers into consecutive destination registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a sequence and captures the other inputs |
| vl | input | 6 | Vector length, 0 to 32 |
| pred | input | 32 | Predicate mask, bit i enables element i |
| rd_base | input | 5 | Destination base register number |
| ra_base | input | 5 | Source 1 base register number |
| rb_base | input | 5 | Source 2 base register number |
| rd_vec | input | 1 | Destination steps per element |
| ra_vec | input | 1 | Source 1 steps per element |
| rb_vec | input | 1 | Source 2 steps per element |
| issue_valid | output | 1 | An element is issued this cycle |
| issue_we | output | 1 | The issued element writes back |
| issue_rd | output | 5 | Destination register index |
| issue_ra | output | 5 | Source 1 register index |
| issue_rb | output | 5 | Source 2 register index |
| issue_elem | output | 6 | Element number being issued |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| src_off | output | 6 | Saved element position |
| sec_off | output | 6 | Saved destination offset |

## Verification
The bench targets a scalar destination whose first set predicate bit is early, late or absent. A design that ignores the early stop writes the destination more than once. A design that does not bound the all-scalar case never reaches done. VL of 0, 1 and 32 and predicate masks with gaps test whether masked elements still use a cycle and still step the vector offsets. An off-by-one there moves every later register index. The splat case and indices that wrap past register 31 show sources that step when they should not, or indices that fail to wrap. A start pulse in the middle of a run shows whether the captured configuration can be overwritten.

// File: rtl/elp_pkg.sv
package elp_pkg;
  localparam int unsigned N_OPS = 3;
  localparam int unsigned OP_RD = 0;
  localparam int unsigned OP_RA = 1;
  localparam int unsigned OP_RB = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/elp_offset.sv
module elp_offset #(
  parameter int unsigned IDX_W = 5,
  parameter int unsigned VL_W  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  input  logic             is_vec,
  input  logic [IDX_W-1:0] base,
  output logic [IDX_W-1:0] idx,
  output logic [VL_W-1:0]  off
);
  localparam int unsigned SUM_W = IDX_W + VL_W;

  logic [SUM_W-1:0] sum;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      off <= '0;
    end else if (step && is_vec) begin
      off <= off + 1'b1;
    end
  end

  always_comb begin
    sum = {{VL_W{1'b0}}, base} + {{IDX_W{1'b0}}, off};
    idx = sum[IDX_W-1:0];
  end
endmodule

// File: rtl/elp_ctrl.sv
module elp_ctrl
  import elp_pkg::*;
#(
  parameter int unsigned MAX_VL = 32,
  parameter int unsigned VL_W   = 6,
  parameter int unsigned ELEM_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [VL_W-1:0]   vl_in,
  input  logic [VL_W-1:0]   cfg_vl,
  input  logic [MAX_VL-1:0] cfg_pred,
  input  logic              cfg_rd_vec,
  output logic              accept,
  output logic              fire,
  output logic              fire_we,
  output logic              finishing,
  output logic [VL_W-1:0]   elem,
  output logic              busy,
  output logic              done
);
  seq_state_t state;
  logic       last;
  logic [VL_W-1:0] elem_nxt;

  always_comb begin
    accept    = (state == ST_IDLE) && start;
    fire      = (state == ST_RUN);
    finishing = (state == ST_FIN);
    fire_we   = fire && cfg_pred[elem[ELEM_W-1:0]];
    elem_nxt  = elem + 1'b1;
    last      = (elem_nxt == cfg_vl) || (!cfg_rd_vec && fire_we);
    busy      = (state != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      elem  <= '0;
      done  <= 1'b0;
    end else begin
      done <= finishing;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            elem  <= '0;
            state <= (vl_in == '0) ? ST_FIN : ST_RUN;
          end
        end
        ST_RUN: begin
          elem <= elem_nxt;
          if (last) state <= ST_FIN;
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/elp_issue_reg.sv
module elp_issue_reg #(
  parameter int unsigned IDX_W = 5,
  parameter int unsigned VL_W  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic             fire_we,
  input  logic             finishing,
  input  logic [VL_W-1:0]  elem,
  input  logic [VL_W-1:0]  dst_off,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [IDX_W-1:0] ra_idx,
  input  logic [IDX_W-1:0] rb_idx,
  output logic             issue_valid,
  output logic             issue_we,
  output logic [IDX_W-1:0] issue_rd,
  output logic [IDX_W-1:0] issue_ra,
  output logic [IDX_W-1:0] issue_rb,
  output logic [VL_W-1:0]  issue_elem,
  output logic [VL_W-1:0]  src_off,
  output logic [VL_W-1:0]  sec_off
);
  always_ff @(posedge clk) begin
    if (rst) begin
      issue_valid <= 1'b0;
      issue_we    <= 1'b0;
      issue_rd    <= '0;
      issue_ra    <= '0;
      issue_rb    <= '0;
      issue_elem  <= '0;
      src_off     <= '0;
      sec_off     <= '0;
    end else begin
      issue_valid <= fire;
      issue_we    <= fire_we;
      if (fire) begin
        issue_rd   <= rd_idx;
        issue_ra   <= ra_idx;
        issue_rb   <= rb_idx;
        issue_elem <= elem;
        src_off    <= elem;
        sec_off    <= dst_off;
      end else if (finishing) begin
        src_off <= '0;
        sec_off <= '0;
      end
    end
  end
endmodule

// File: rtl/elem_loop_seq.sv
module elem_loop_seq
  import elp_pkg::*;
#(
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned MAX_VL = 32,
  parameter int unsigned VL_W   = $clog2(MAX_VL + 1),
  parameter int unsigned ELEM_W = $clog2(MAX_VL)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [VL_W-1:0]   vl,
  input  logic [MAX_VL-1:0] pred,
  input  logic [IDX_W-1:0]  rd_base,
  input  logic [IDX_W-1:0]  ra_base,
  input  logic [IDX_W-1:0]  rb_base,
  input  logic              rd_vec,
  input  logic              ra_vec,
  input  logic              rb_vec,
  output logic              issue_valid,
  output logic              issue_we,
  output logic [IDX_W-1:0]  issue_rd,
  output logic [IDX_W-1:0]  issue_ra,
  output logic [IDX_W-1:0]  issue_rb,
  output logic [VL_W-1:0]   issue_elem,
  output logic              busy,
  output logic              done,
  output logic [VL_W-1:0]   src_off,
  output logic [VL_W-1:0]   sec_off
);
  logic [VL_W-1:0]   cfg_vl;
  logic [MAX_VL-1:0] cfg_pred;
  logic [N_OPS-1:0]  cfg_vec;
  logic [N_OPS-1:0][IDX_W-1:0] cfg_base;
  logic              cfg_rd_vec;

  logic accept, fire, fire_we, finishing;
  logic [VL_W-1:0] elem;
  logic [N_OPS-1:0][IDX_W-1:0] op_idx;
  logic [N_OPS-1:0][VL_W-1:0]  op_off;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_vl   <= '0;
      cfg_pred <= '0;
      cfg_vec  <= '0;
      cfg_base <= '0;
    end else if (accept) begin
      cfg_vl          <= vl;
      cfg_pred        <= pred;
      cfg_vec         <= {rb_vec, ra_vec, rd_vec};
      cfg_base[OP_RD] <= rd_base;
      cfg_base[OP_RA] <= ra_base;
      cfg_base[OP_RB] <= rb_base;
    end
  end

  assign cfg_rd_vec = cfg_vec[OP_RD];

  elp_ctrl #(.MAX_VL(MAX_VL), .VL_W(VL_W), .ELEM_W(ELEM_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .vl_in(vl),
    .cfg_vl(cfg_vl), .cfg_pred(cfg_pred), .cfg_rd_vec(cfg_rd_vec),
    .accept(accept), .fire(fire), .fire_we(fire_we), .finishing(finishing),
    .elem(elem), .busy(busy), .done(done)
  );

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    elp_offset #(.IDX_W(IDX_W), .VL_W(VL_W)) u_off (
      .clk(clk), .rst(rst), .clear(accept), .step(fire),
      .is_vec(cfg_vec[g]), .base(cfg_base[g]),
      .idx(op_idx[g]), .off(op_off[g])
    );
  end

  elp_issue_reg #(.IDX_W(IDX_W), .VL_W(VL_W)) u_issue (
    .clk(clk), .rst(rst), .fire(fire), .fire_we(fire_we), .finishing(finishing),
    .elem(elem), .dst_off(op_off[OP_RD]),
    .rd_idx(op_idx[OP_RD]), .ra_idx(op_idx[OP_RA]), .rb_idx(op_idx[OP_RB]),
    .issue_valid(issue_valid), .issue_we(issue_we),
    .issue_rd(issue_rd), .issue_ra(issue_ra), .issue_rb(issue_rb),
    .issue_elem(issue_elem), .src_off(src_off), .sec_off(sec_off)
  );
endmodule

// File: rtl/elp_checker.sv
module elp_checker #(
  parameter int unsigned IDX_W = 5,
  parameter int unsigned VL_W  = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             done,
  input logic             issue_valid,
  input logic             issue_we,
  input logic [IDX_W-1:0] issue_rd,
  input logic [VL_W-1:0]  issue_elem,
  input logic [VL_W-1:0]  src_off,
  input logic [VL_W-1:0]  sec_off,
  input logic [VL_W-1:0]  cfg_vl,
  input logic             cfg_rd_vec
);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !issue_valid);

  assert_elem_step_R3: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && $past(issue_valid)) |-> (issue_elem == $past(issue_elem) + 1'b1));

  assert_we_needs_valid_R4: assert property (@(posedge clk) disable iff (rst)
    issue_we |-> issue_valid);

  assert_dst_step_R5: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && $past(issue_valid) && cfg_rd_vec) |-> (issue_rd == $past(issue_rd) + 1'b1));

  assert_scalar_stop_R6: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_we && !cfg_rd_vec) |=> !issue_valid);

  assert_elem_bound_R7: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> (issue_elem < cfg_vl));

  assert_srcoff_track_R8: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> (src_off == issue_elem));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_clean_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (src_off == '0 && sec_off == '0 && !issue_valid && !busy));
endmodule

bind elem_loop_seq elp_checker #(.IDX_W(IDX_W), .VL_W(VL_W)) u_elp_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done),
  .issue_valid(issue_valid), .issue_we(issue_we), .issue_rd(issue_rd),
  .issue_elem(issue_elem), .src_off(src_off), .sec_off(sec_off),
  .cfg_vl(cfg_vl), .cfg_rd_vec(cfg_rd_vec)
);

// File: tb/test_elem_loop_seq.sv
module test_elem_loop_seq;
  localparam int IDX_W = 5;
  localparam int MAX_VL = 32;
  localparam int VL_W = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [VL_W-1:0] vl = '0;
  logic [MAX_VL-1:0] pred = '0;
  logic [IDX_W-1:0] rd_base = '0, ra_base = '0, rb_base = '0;
  logic rd_vec = 1'b0, ra_vec = 1'b0, rb_vec = 1'b0;
  logic issue_valid, issue_we, busy, done;
  logic [IDX_W-1:0] issue_rd, issue_ra, issue_rb;
  logic [VL_W-1:0] issue_elem, src_off, sec_off;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [31:0] rf [32];
  logic [31:0] ref_rf [32];
  int exp_n;
  int exp_rd [32], exp_ra [32], exp_rb [32], exp_we [32], exp_do [32];

  always #2 clk = ~clk;

  elem_loop_seq i_elem_loop_seq (
    .clk(clk), .rst(rst), .start(start), .vl(vl), .pred(pred),
    .rd_base(rd_base), .ra_base(ra_base), .rb_base(rb_base),
    .rd_vec(rd_vec), .ra_vec(ra_vec), .rb_vec(rb_vec),
    .issue_valid(issue_valid), .issue_we(issue_we),
    .issue_rd(issue_rd), .issue_ra(issue_ra), .issue_rb(issue_rb),
    .issue_elem(issue_elem), .busy(busy), .done(done),
    .src_off(src_off), .sec_off(sec_off)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic void build_expect(input int n, input logic [31:0] p,
                                       input int rdb, input int rab, input int rbb,
                                       input bit dv, input bit av, input bit bv);
    int od = 0, oa = 0, ob = 0;
    exp_n = 0;
    for (int i = 0; i < n; i++) begin
      exp_rd[i] = (rdb + od) % 32;
      exp_ra[i] = (rab + oa) % 32;
      exp_rb[i] = (rbb + ob) % 32;
      exp_we[i] = int'(p[i]);
      exp_do[i] = od;
      exp_n++;
      if (p[i]) ref_rf[exp_rd[i]] = ref_rf[exp_ra[i]] + ref_rf[exp_rb[i]];
      if (!dv && p[i]) break;
      if (dv) od++;
      if (av) oa++;
      if (bv) ob++;
    end
  endfunction

  task automatic run_op(input int n, input logic [31:0] p,
                        input int rdb, input int rab, input int rbb,
                        input bit dv, input bit av, input bit bv, input bit poke);
    int cnt = 0;
    bit got_done = 1'b0;
    build_expect(n, p, rdb, rab, rbb, dv, av, bv);
    @(negedge clk);
    vl = VL_W'(n); pred = p;
    rd_base = IDX_W'(rdb); ra_base = IDX_W'(rab); rb_base = IDX_W'(rbb);
    rd_vec = dv; ra_vec = av; rb_vec = bv;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    vl = '0; pred = '0; rd_base = '0; ra_base = '0; rb_base = '0;
    rd_vec = 1'b0; ra_vec = 1'b0; rb_vec = 1'b0;
    check(busy == 1'b1, "R2 busy after start", busy, 1);
    for (int it = 1; it <= 40; it++) begin
      if (poke && it == 2) begin
        vl = 6'd1; pred = '1; rd_base = 5'd7; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      if (issue_valid) begin
        if (cnt < exp_n) begin
          check(int'(issue_elem) == cnt, "R3 element number", issue_elem, cnt);
          check(int'(issue_we) == exp_we[cnt], "R4 write enable", issue_we, exp_we[cnt]);
          check(int'(issue_rd) == exp_rd[cnt], "R5 dest index", issue_rd, exp_rd[cnt]);
          check(int'(issue_ra) == exp_ra[cnt], "R5 src1 index", issue_ra, exp_ra[cnt]);
          check(int'(issue_rb) == exp_rb[cnt], "R5 src2 index", issue_rb, exp_rb[cnt]);
          check(int'(src_off) == cnt, "R8 src_off", src_off, cnt);
          check(int'(sec_off) == exp_do[cnt], "R8 sec_off", sec_off, exp_do[cnt]);
          check(busy == 1'b1, "R2 busy during run", busy, 1);
        end
        if (issue_we) rf[issue_rd] = rf[issue_ra] + rf[issue_rb];
        cnt++;
      end
      if (done) begin
        got_done = 1'b1;
        check(it == exp_n + 1, "R9 done timing", it, exp_n + 1);
        if (n == 0) check(it == 1, "R10 empty done", it, 1);
        check(!issue_valid && !busy, "R9 quiet at done", {issue_valid, busy}, 0);
        check(src_off == '0 && sec_off == '0, "R9 offsets cleared", {src_off, sec_off}, 0);
        break;
      end
    end
    start = 1'b0;
    check(got_done, "R9 done seen", got_done, 1);
    check(cnt == exp_n, "R6 R7 issue count", cnt, exp_n);
    @(negedge clk);
    check(done == 1'b0, "R9 single pulse", done, 0);
    for (int r = 0; r < 32; r++)
      check(rf[r] == ref_rf[r], "R11 R6 register file", rf[r], ref_rf[r]);
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int r = 0; r < 32; r++) begin
      rf[r] = $urandom;
      ref_rf[r] = rf[r];
    end
    repeat (3) @(negedge clk);
    check(!busy && !done && !issue_valid && !issue_we, "R1 reset outputs",
          {busy, done, issue_valid, issue_we}, 0);
    check(src_off == '0 && sec_off == '0, "R1 reset offsets", {src_off, sec_off}, 0);
    rst = 1'b0;
    @(negedge clk);
    // R10: empty vector
    run_op(0, 32'hFFFF_FFFF, 1, 2, 3, 1, 1, 1, 0);
    // R11: splat into 6 registers
    run_op(6, 32'h0000_003F, 10, 2, 3, 1, 0, 0, 0);
    for (int k = 1; k < 6; k++)
      check(rf[10 + k] == rf[10], "R11 splat value", rf[10 + k], rf[10]);
    // R6: scalar destination, first active element late
    run_op(8, 32'h0000_0050, 4, 8, 16, 0, 1, 1, 0);
    // R6 R7: scalar destination, all scalar, no active bit
    run_op(5, 32'h0, 4, 8, 16, 0, 0, 0, 0);
    // R7: full length with gaps, wrapping indices
    run_op(32, 32'hA5A5_0F0F, 28, 30, 1, 1, 1, 0, 0);
    // R2: start during a run is ignored
    run_op(7, 32'h0000_007B, 3, 12, 20, 1, 1, 1, 1);
    // R7: length one
    run_op(1, 32'h1, 31, 31, 0, 1, 1, 1, 0);
    for (int t = 0; t < 40; t++) begin
      run_op(int'($urandom_range(0, 32)), $urandom, int'($urandom_range(0, 31)),
             int'($urandom_range(0, 31)), int'($urandom_range(0, 31)),
             1'($urandom), 1'($urandom), 1'($urandom), 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule